// File: doc/BRIEF.md
# I2C FRU EEPROM Emulation Target

This block is an I2C target that looks like a serial EEPROM holding field-replaceable-unit inventory data. A management controller sharing the bus reads it the same way it reads a real two-byte-addressed EEPROM. First it writes a 16-bit offset. Then it issues a repeated START with the read address and clocks data bytes out. The data comes from a read-only image built into the block. The image is generated from parameters, and its length is a parameter too.

The block sees the bus through sampled SCL and SDA inputs. It pulls SDA low with a drive-enable output, and the pad is open drain. It never stretches the clock. It never changes the image. Each read returns at most 255 real data bytes. Any read that has no valid offset, that runs past the end of the image, or that goes past the per-read cap returns 0xFF.

Top module: `fru_eeprom_i2c`

## Requirements
- R1: The block answers only the 7-bit address `DEV_ADDR` (default 0x50, which is 0xA0 for a write and 0xA1 for a read on the wire). It ACKs a matching address byte. For any other address it leaves SDA released until the next START or STOP.
- R2: In the write phase the block ACKs every data byte. The first data byte is the offset's low byte and the second is its high byte.
- R3: After a repeated START with the read address, the first byte returned is the one stored at the latched offset. Each later byte comes from the next offset, one higher.
- R4: A byte whose offset is `FRU_LEN` or more reads as 0xFF.
- R5: A single read returns at most `MAX_RD` (255) image bytes. The 256th byte and every byte after it read as 0xFF.
- R6: A read returns 0xFF for every byte in two cases: when the write phase since the last STOP supplied only one offset byte, and when no offset byte was written since the last STOP.
- R7: Write bytes after the second offset byte are ACKed and then discarded. They change neither the offset nor the image.
- R8: When the controller NACKs a read byte, the block releases SDA and stays released until a STOP or a START. A read may be ended this way after any number of bytes.
- R9: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. A START that arrives in the middle of a byte drops that byte and begins a new address byte.
- R10: The block only begins pulling SDA low while SCL is low. A STOP releases SDA.
- R11: Image byte i is `(i[7:0]*IMG_MULT + i[15:8] + IMG_SEED) mod 256`. After reset, SDA is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |

## Verification
A wrong offset register shows up directly: the very first data byte after the repeated START differs from the image value at the requested offset. A byte counter that slips shows up at the byte where the 0xFF padding should or should not begin. Bit-counter or state errors show up on the bus itself. Typically an ACK is missing at the ninth clock of a byte, or SDA stays pulled low after a controller NACK or after a STOP. The bench catches these within one byte time. Its per-clock monitor also flags any SDA drive that begins while SCL is high.

// File: rtl/fru_pkg.sv
package fru_pkg;

    localparam int BYTE_W = 8;
    localparam int OFS_W  = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_WBYTE,
        ST_WACK,
        ST_RBYTE,
        ST_RACK,
        ST_WAIT
    } tgt_state_e;

    // Bus events derived from the synchronised lines.
    typedef struct packed {
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    // Image content generator: low index byte scaled, high byte added, plus seed.
    function automatic logic [BYTE_W-1:0] img_byte(
        input logic [OFS_W-1:0]  idx,
        input logic [BYTE_W-1:0] seed,
        input logic [BYTE_W-1:0] mult
    );
        logic [BYTE_W-1:0] prod;
        prod = idx[7:0] * mult;
        return prod + idx[15:8] + seed;
    endfunction

endpackage

// File: rtl/fru_line_sync.sv
module fru_line_sync
    import fru_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output logic    scl_lvl,
    output bus_ev_t ev
);
    localparam int PIPE_W = SYNC_STAGES + 1;

    logic [PIPE_W-1:0] scl_p;
    logic [PIPE_W-1:0] sda_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= '1;
            sda_p <= '1;
        end else begin
            scl_p <= {scl_p[PIPE_W-2:0], scl_i};
            sda_p <= {sda_p[PIPE_W-2:0], sda_i};
        end
    end

    logic scl_s, scl_q, sda_s, sda_q;
    assign scl_s = scl_p[SYNC_STAGES-1];
    assign scl_q = scl_p[SYNC_STAGES];
    assign sda_s = sda_p[SYNC_STAGES-1];
    assign sda_q = sda_p[SYNC_STAGES];

    assign scl_lvl     = scl_s;
    assign ev.sda      = sda_s;
    assign ev.scl_rise = scl_s & ~scl_q;
    assign ev.scl_fall = ~scl_s & scl_q;
    assign ev.start    = scl_s & scl_q & sda_q & ~sda_s;
    assign ev.stop     = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/fru_rom.sv
module fru_rom
    import fru_pkg::*;
#(
    parameter int                FRU_LEN  = 300,
    parameter logic [BYTE_W-1:0] IMG_SEED = 8'h5A,
    parameter logic [BYTE_W-1:0] IMG_MULT = 8'd37
) (
    input  logic [OFS_W-1:0]  addr,
    output logic [BYTE_W-1:0] data
);
    localparam int                IDX_W = (FRU_LEN > 1) ? $clog2(FRU_LEN) : 1;
    localparam logic [OFS_W:0]    LEN_V = (OFS_W+1)'(FRU_LEN);

    logic [BYTE_W-1:0] mem [FRU_LEN];

    for (genvar g = 0; g < FRU_LEN; g++) begin : g_img
        assign mem[g] = img_byte(OFS_W'(g), IMG_SEED, IMG_MULT);
    end

    logic in_range;
    assign in_range = ({1'b0, addr} < LEN_V);
    assign data     = in_range ? mem[addr[IDX_W-1:0]] : 8'hFF;

endmodule

// File: rtl/fru_tgt_fsm.sv
module fru_tgt_fsm
    import fru_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h50,
    parameter int         MAX_RD   = 255
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic [BYTE_W-1:0] rom_data,
    output logic [OFS_W-1:0]  rom_addr,
    output logic              sda_oe,
    output tgt_state_e        state
);
    localparam int              CW      = $clog2(MAX_RD + 1);
    localparam logic [CW-1:0]   RD_LIM  = CW'(MAX_RD);

    logic [3:0]        bit_cnt;
    logic [BYTE_W-1:0] rx_sh;
    logic [BYTE_W-1:0] tx_sh;
    logic [OFS_W-1:0]  ofs;
    logic [1:0]        wr_cnt;
    logic [CW-1:0]     rd_cnt;
    logic              rd_dir;
    logic              m_ack;

    // Byte the target would send next.
    logic              ofs_ok;
    logic [BYTE_W-1:0] nxt_byte;
    assign ofs_ok   = (wr_cnt == 2'd2) && (rd_cnt < RD_LIM);
    assign nxt_byte = ofs_ok ? rom_data : 8'hFF;
    assign rom_addr = ofs;

    logic [CW-1:0] rd_cnt_inc;
    assign rd_cnt_inc = (rd_cnt < RD_LIM) ? rd_cnt + 1'b1 : rd_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            rx_sh   <= '0;
            tx_sh   <= '1;
            ofs     <= '0;
            wr_cnt  <= '0;
            rd_cnt  <= '0;
            rd_dir  <= 1'b0;
            m_ack   <= 1'b0;
            sda_oe  <= 1'b0;
        end else if (ev.start) begin
            state   <= ST_ADDR;
            bit_cnt <= '0;
            sda_oe  <= 1'b0;
        end else if (ev.stop) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            wr_cnt  <= '0;
            sda_oe  <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE, ST_WAIT: begin
                    sda_oe <= 1'b0;
                end
                ST_ADDR, ST_WBYTE: begin
                    if (ev.scl_rise && bit_cnt < 4'd8) begin
                        rx_sh   <= {rx_sh[6:0], ev.sda};
                        bit_cnt <= bit_cnt + 1'b1;
                    end else if (ev.scl_fall && bit_cnt == 4'd8) begin
                        bit_cnt <= '0;
                        if (state == ST_ADDR) begin
                            if (rx_sh[7:1] == DEV_ADDR) begin
                                sda_oe <= 1'b1;
                                state  <= ST_AACK;
                                rd_dir <= rx_sh[0];
                                if (rx_sh[0]) rd_cnt <= '0;
                                else          wr_cnt <= '0;
                            end else begin
                                state <= ST_WAIT;
                            end
                        end else begin
                            sda_oe <= 1'b1;
                            state  <= ST_WACK;
                            if (wr_cnt == 2'd0) begin
                                ofs[7:0] <= rx_sh;
                                wr_cnt   <= 2'd1;
                            end else if (wr_cnt == 2'd1) begin
                                ofs[15:8] <= rx_sh;
                                wr_cnt    <= 2'd2;
                            end
                        end
                    end
                end
                ST_AACK: begin
                    if (ev.scl_fall) begin
                        bit_cnt <= '0;
                        if (rd_dir) begin
                            tx_sh  <= nxt_byte;
                            sda_oe <= ~nxt_byte[7];
                            ofs    <= ofs + 1'b1;
                            rd_cnt <= rd_cnt_inc;
                            state  <= ST_RBYTE;
                        end else begin
                            sda_oe <= 1'b0;
                            state  <= ST_WBYTE;
                        end
                    end
                end
                ST_WACK: begin
                    if (ev.scl_fall) begin
                        sda_oe  <= 1'b0;
                        bit_cnt <= '0;
                        state   <= ST_WBYTE;
                    end
                end
                ST_RBYTE: begin
                    if (ev.scl_rise && bit_cnt < 4'd8) begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end else if (ev.scl_fall) begin
                        if (bit_cnt == 4'd8) begin
                            sda_oe  <= 1'b0;
                            bit_cnt <= '0;
                            m_ack   <= 1'b0;
                            state   <= ST_RACK;
                        end else if (bit_cnt != 4'd0) begin
                            tx_sh  <= {tx_sh[6:0], 1'b1};
                            sda_oe <= ~tx_sh[6];
                        end
                    end
                end
                ST_RACK: begin
                    if (ev.scl_rise) begin
                        m_ack <= ~ev.sda;
                    end else if (ev.scl_fall) begin
                        if (m_ack) begin
                            tx_sh  <= nxt_byte;
                            sda_oe <= ~nxt_byte[7];
                            ofs    <= ofs + 1'b1;
                            rd_cnt <= rd_cnt_inc;
                            state  <= ST_RBYTE;
                        end else begin
                            sda_oe <= 1'b0;
                            state  <= ST_WAIT;
                        end
                    end
                end
                default: begin
                    state  <= ST_IDLE;
                    sda_oe <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/fru_eeprom_i2c.sv
module fru_eeprom_i2c
    import fru_pkg::*;
#(
    parameter logic [6:0]        DEV_ADDR    = 7'h50,
    parameter int                FRU_LEN     = 300,
    parameter logic [BYTE_W-1:0] IMG_SEED    = 8'h5A,
    parameter logic [BYTE_W-1:0] IMG_MULT    = 8'd37,
    parameter int                MAX_RD      = 255,
    parameter int                SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe
);
    bus_ev_t           ev;
    logic              scl_lvl;
    logic [OFS_W-1:0]  rom_addr;
    logic [BYTE_W-1:0] rom_data;
    tgt_state_e        state;

    fru_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .scl_i   (scl_i),
        .sda_i   (sda_i),
        .scl_lvl (scl_lvl),
        .ev      (ev)
    );

    fru_rom #(
        .FRU_LEN  (FRU_LEN),
        .IMG_SEED (IMG_SEED),
        .IMG_MULT (IMG_MULT)
    ) u_rom (
        .addr (rom_addr),
        .data (rom_data)
    );

    fru_tgt_fsm #(
        .DEV_ADDR (DEV_ADDR),
        .MAX_RD   (MAX_RD)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .rom_data (rom_data),
        .rom_addr (rom_addr),
        .sda_oe   (sda_oe),
        .state    (state)
    );

endmodule

// File: rtl/fru_eeprom_i2c_chk.sv
module fru_eeprom_i2c_chk
    import fru_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       scl_lvl,
    input logic       start_det,
    input logic       stop_det,
    input tgt_state_e state,
    input logic       sda_oe
);
    // R10: a new low drive on SDA only begins while SCL is low
    a_r10_drive_scl_low: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_lvl);

    // R10: STOP leaves SDA released
    a_r10_stop_release: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> (!sda_oe && state == ST_IDLE));

    // R9: START restarts address reception with SDA released
    a_r9_start_restart: assert property (@(posedge clk) disable iff (rst)
        start_det |=> (!sda_oe && state == ST_ADDR));

    // R8 / R1: a target that has stepped aside never pulls SDA
    a_r8_wait_released: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT) |-> !sda_oe);

    // R2: acknowledge slots keep SDA low
    a_r2_ack_slot_low: assert property (@(posedge clk) disable iff (rst)
        (state == ST_AACK || state == ST_WACK) |-> sda_oe);

endmodule

bind fru_eeprom_i2c fru_eeprom_i2c_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .scl_lvl   (scl_lvl),
    .start_det (ev.start),
    .stop_det  (ev.stop),
    .state     (state),
    .sda_oe    (sda_oe)
);

// File: tb/tb_fru_eeprom_i2c.sv
module tb_fru_eeprom_i2c;
    localparam int LEN = 300;
    localparam int SEED = 8'h5A;
    localparam int MULT = 37;
    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_c = 1'b1;
    logic sda_c = 1'b1;
    logic sda_oe;
    logic sda_line;

    assign sda_line = sda_c & ~sda_oe;

    always #10 clk = ~clk;

    fru_eeprom_i2c dut (
        .clk    (clk),
        .rst    (rst),
        .scl_i  (scl_c),
        .sda_i  (sda_line),
        .sda_oe (sda_oe)
    );

    int n_run = 0;
    int n_fail = 0;
    int r10_viol = 0;
    logic prev_oe = 1'b0;

    task automatic ck(input bit ok, input string rq, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", rq, act, exp);
        end
    endtask

    // R10 monitor, every clock: drive must not begin while SCL is high
    always @(posedge clk) begin
        if (!rst) begin
            if (sda_oe && !prev_oe && scl_c) r10_viol++;
        end
        prev_oe <= sda_oe;
    end

    function automatic int img(input int i);
        return ((i % 256) * MULT + (i / 256) + SEED) % 256;
    endfunction

    function automatic int model(input int off, input int idx, input int nofs);
        if (nofs < 2 || idx >= 255 || off + idx >= LEN) return 8'hFF;
        return img(off + idx);
    endfunction

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_c = 1; scl_c = 1; w(Q);
        sda_c = 0; w(Q);
        scl_c = 0; w(2);
    endtask

    task automatic bus_rstart();
        sda_c = 1; w(Q);
        scl_c = 1; w(Q);
        sda_c = 0; w(Q);
        scl_c = 0; w(2);
    endtask

    task automatic bus_stop();
        sda_c = 0; w(Q);
        scl_c = 1; w(Q);
        sda_c = 1; w(Q);
    endtask

    task automatic send_bit(input bit b);
        sda_c = b; w(Q);
        scl_c = 1; w(Q);
        scl_c = 0; w(2);
    endtask

    task automatic wr_byte(input int b, output bit ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_c = 1; w(Q);
        scl_c = 1; w(Q / 2);
        ack = !sda_line;
        w(Q / 2);
        scl_c = 0; w(2);
    endtask

    task automatic rd_byte(input bit ack, output int b);
        b = 0;
        sda_c = 1;
        for (int i = 0; i < 8; i++) begin
            w(Q);
            scl_c = 1; w(Q / 2);
            b = (b << 1) | int'(sda_line);
            w(Q / 2);
            scl_c = 0; w(2);
        end
        sda_c = ack ? 1'b0 : 1'b1; w(Q);
        scl_c = 1; w(Q);
        scl_c = 0; w(2);
        sda_c = 1;
    endtask

    // Offset write (nofs bytes, plus extra), repeated START, n reads, NACK last.
    task automatic fru_read(input int off, input int nofs, input int extra,
                            input int n, input string rq);
        bit a;
        int d;
        bus_start();
        wr_byte(8'hA0, a);
        ck(a, "R1 write address ACK", int'(a), 1);
        for (int k = 0; k < nofs; k++) begin
            wr_byte(k == 0 ? off % 256 : off / 256, a);
            ck(a, "R2 offset byte ACK", int'(a), 1);
        end
        for (int k = 0; k < extra; k++) begin
            wr_byte(8'h77 + k, a);
            ck(a, "R7 extra write byte ACK", int'(a), 1);
        end
        if (nofs > 0 || extra > 0) bus_rstart();
        else begin
            bus_stop();
            bus_start();
        end
        wr_byte(8'hA1, a);
        ck(a, "R1 read address ACK", int'(a), 1);
        for (int i = 0; i < n; i++) begin
            rd_byte(i < n - 1, d);
            ck(d == model(off, i, (nofs == 0 && extra == 0) ? 0 : nofs), rq,
               d, model(off, i, (nofs == 0 && extra == 0) ? 0 : nofs));
        end
        w(4);
        ck(!sda_oe, "R8 SDA released after NACK", int'(sda_oe), 0);
        bus_stop();
        ck(!sda_oe, "R10 SDA released after STOP", int'(sda_oe), 0);
    endtask

    initial begin
        bit a;
        int d;
        w(5);
        rst = 0;
        w(2);
        ck(!sda_oe, "R11 reset releases SDA", int'(sda_oe), 0);

        fru_read(0, 2, 0, 16, "R3 R11 data from offset 0");
        fru_read(50, 2, 0, 32, "R3 data from offset 50");
        fru_read(256, 2, 0, 10, "R2 high offset byte used");
        fru_read(290, 2, 0, 20, "R4 pad past image end");
        fru_read(5, 1, 0, 4, "R6 one offset byte gives 0xFF");
        fru_read(0, 0, 0, 3, "R6 no offset since STOP gives 0xFF");
        fru_read(16, 2, 2, 8, "R7 extra write bytes ignored");
        fru_read(0, 2, 0, 260, "R5 cap at 255 bytes");

        // R1: foreign address is not acknowledged
        bus_start();
        wr_byte(8'hA2, a);
        ck(!a, "R1 foreign address NACK", int'(a), 0);
        wr_byte(8'h00, a);
        ck(!a, "R1 no drive after foreign address", int'(a), 0);
        bus_stop();

        // R9: START in the middle of a byte aborts it
        bus_start();
        wr_byte(8'hA0, a);
        ck(a, "R9 address ACK before abort", int'(a), 1);
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        bus_rstart();
        wr_byte(8'hA0, a);
        ck(a, "R9 address ACK after mid-byte START", int'(a), 1);
        wr_byte(8'd7, a);
        wr_byte(8'd0, a);
        bus_rstart();
        wr_byte(8'hA1, a);
        for (int i = 0; i < 4; i++) begin
            rd_byte(i < 3, d);
            ck(d == img(7 + i), "R9 read after aborted byte", d, img(7 + i));
        end
        bus_stop();

        ck(r10_viol == 0, "R10 drive began while SCL high", r10_viol, 0);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule